// File: doc/BRIEF.md
# Banked CPU Register File

This block holds the programmer-visible registers of a small 16-bit microcontroller core. Seven registers (four data words, two address words and a frame base) exist twice, once per bank, and the active copy is picked by a bit in the flag word. A second group of registers exists only once and is shared by both banks: a static base, a user stack pointer, an interrupt stack pointer, the flag word, a 20-bit interrupt table base and a 20-bit program counter. Another flag bit picks which stack pointer is driven on the active stack-pointer output and is reached through the "active SP" selector.

The core uses one synchronous write port and one combinational read port. Each port takes a 4-bit register selector and a 2-bit access size. Separately, a flag update port lets the flag-computing logic load the flag word in the same cycle as a register write. The program counter, flag word, interrupt table base and active stack pointer also drive dedicated outputs. A selector/size pair that names no real access is refused. Such a write raises a one-cycle error pulse.

Top module: `cpu_regset`

## Requirements
- R1: While reset is low and after it is released, every data, address, frame-base, static-base and stack register in both banks reads 0. The flag word reads 0, so bank 0 and the interrupt stack pointer are active. The interrupt table base is 0, the program counter equals `reset_vec`, and `err_o` is 0.
- R2: Selector codes are 0 R0, 1 R1, 2 R2, 3 R3, 4 A0, 5 A1, 6 FB, 7 SB, 8 USP, 9 ISP, 10 active SP, 11 flag word, 12 table-base low 16 bits, 13 table-base high 4 bits, 14 PC and 15 none. Size codes are 0 low byte, 1 high byte, 2 word and 3 32-bit. A word write to codes 0 to 9 stores `wr_data[15:0]`, and a later word read of the same code returns it zero-extended.
- R3: R0 and R1 accept byte sizes. A low-byte write stores `wr_data[7:0]` in bits 7:0 and a high-byte write stores `wr_data[7:0]` in bits 15:8, leaving the other half untouched. A byte read returns the selected half in `rd_data[7:0]` with all upper bits 0.
- R4: A 32-bit access on R0 addresses {R2,R0} and on R1 addresses {R3,R1}, the higher-numbered register holding bits 31:16. A 32-bit write updates both halves in the same clock edge.
- R5: Flag bit 4 selects the bank for every access to codes 0 to 6. The two banks hold independent values.
- R6: Flag bit 7 selects the stack pointer. With bit 7 = 0, `sp_o` shows ISP and code 10 reads and writes ISP. With bit 7 = 1, both go to USP.
- R7: Flag bits 0 to 7 are carry, debug, zero, sign, bank select, overflow, interrupt enable and stack select. Bits 14:12 hold a 3-bit interrupt priority level. All other flag bits read 0 and ignore writes (writable mask 0x70FF).
- R8: A word write to code 12 loads table-base bits 15:0. A word write to code 13 loads bits 19:16 from `wr_data[3:0]`. `intb_o` shows the full 20 bits, and a read of code 13 returns the upper part zero-extended.
- R9: A 32-bit write to code 14 loads the program counter from `wr_data[19:0]`. A 32-bit read of code 14 returns it zero-extended. The program counter changes only on such a write.
- R10: A flag change takes effect for reads and writes from the next clock cycle. A banked-register write in the same cycle as a bank-select change goes to the previously selected bank. When the write port targets the flag word in the same cycle as the flag update port, the write port wins.
- R11: The only legal combinations are any size on codes 0 and 1, word size on codes 2 to 13, and 32-bit size on code 14. An illegal write changes no register and sets `err_o` high for exactly the following cycle. An illegal read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| reset_vec | input | 20 | Program counter value loaded during reset |
| wr_en | input | 1 | Write request |
| wr_sel | input | 4 | Write register selector |
| wr_size | input | 2 | Write access size |
| wr_data | input | 32 | Write data |
| flg_upd_en | input | 1 | Flag update request from flag logic |
| flg_upd_val | input | 16 | Flag update value |
| rd_sel | input | 4 | Read register selector |
| rd_size | input | 2 | Read access size |
| rd_data | output | 32 | Combinational read data |
| sp_o | output | 16 | Active stack pointer |
| flg_o | output | 16 | Flag word |
| pc_o | output | 20 | Program counter |
| intb_o | output | 20 | Interrupt table base |
| err_o | output | 1 | One-cycle pulse after an illegal write |

## Verification
The assertions check on every cycle that reserved flag bits stay 0 and that an illegal read returns 0. They also check that the error pulse follows exactly the illegal writes, that an illegal write leaves the visible registers unchanged, and that the program counter and active stack pointer hold when nothing targets them. Several behaviours can only be shown by the directed scenarios, because they involve a stored value being read back later:
- byte-half merging,
- pair splitting,
- independence of the two banks,
- the one-cycle delay of a bank switch with its simultaneous write landing in the old bank,
- write-port priority over the flag update port.

// File: rtl/regset_pkg.sv
package regset_pkg;

   typedef enum logic [3:0] {
      SEL_R0   = 4'd0,
      SEL_R1   = 4'd1,
      SEL_R2   = 4'd2,
      SEL_R3   = 4'd3,
      SEL_A0   = 4'd4,
      SEL_A1   = 4'd5,
      SEL_FB   = 4'd6,
      SEL_SB   = 4'd7,
      SEL_USP  = 4'd8,
      SEL_ISP  = 4'd9,
      SEL_SP   = 4'd10,
      SEL_FLG  = 4'd11,
      SEL_TBLO = 4'd12,
      SEL_TBHI = 4'd13,
      SEL_PC   = 4'd14,
      SEL_NONE = 4'd15
   } sel_e;

   typedef enum logic [1:0] {
      SZ_LO   = 2'd0,
      SZ_HI   = 2'd1,
      SZ_WORD = 2'd2,
      SZ_PAIR = 2'd3
   } size_e;

   localparam int BANK_REGS = 7;
   localparam int IDX_W     = 3;

   localparam int FLG_C   = 0;
   localparam int FLG_D   = 1;
   localparam int FLG_Z   = 2;
   localparam int FLG_S   = 3;
   localparam int FLG_B   = 4;
   localparam int FLG_O   = 5;
   localparam int FLG_I   = 6;
   localparam int FLG_U   = 7;
   localparam int IPL_LSB = 12;
   localparam int IPL_W   = 3;

   typedef struct packed {
      logic             legal;
      logic             bank_hit;
      logic [IDX_W-1:0] bank_idx;
      logic             be_lo;
      logic             be_hi;
      logic             pair;
   } dec_t;

endpackage

// File: rtl/regset_decode.sv
module regset_decode
   import regset_pkg::*;
(
   input  logic [3:0] sel,
   input  logic [1:0] size,
   output dec_t       dec
);

   sel_e  s;
   size_e z;

   assign s = sel_e'(sel);
   assign z = size_e'(size);

   always_comb begin
      dec          = '0;
      dec.bank_idx = sel[IDX_W-1:0];
      dec.bank_hit = (sel <= 4'(SEL_FB));
      unique case (s)
         SEL_R0, SEL_R1: begin
            dec.legal = 1'b1;
            dec.be_lo = (z != SZ_HI);
            dec.be_hi = (z != SZ_LO);
            dec.pair  = (z == SZ_PAIR);
         end
         SEL_PC: begin
            dec.legal = (z == SZ_PAIR);
         end
         SEL_NONE: begin
            dec.legal = 1'b0;
         end
         default: begin
            dec.legal = (z == SZ_WORD);
            dec.be_lo = 1'b1;
            dec.be_hi = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/regset_bank.sv
module regset_bank
   import regset_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int NUM_BANKS = 2
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [$clog2(NUM_BANKS)-1:0]         bank_sel,
   input  logic                                 we0,
   input  logic [IDX_W-1:0]                     idx0,
   input  logic [1:0]                           be0,
   input  logic [DATA_W-1:0]                    wd0,
   input  logic                                 we1,
   input  logic [IDX_W-1:0]                     idx1,
   input  logic [DATA_W-1:0]                    wd1,
   output logic [BANK_REGS-1:0][DATA_W-1:0]     act_q
);

   localparam int HALF_W = DATA_W / 2;
   localparam int SEL_W  = $clog2(NUM_BANKS);

   logic [NUM_BANKS-1:0][BANK_REGS-1:0][DATA_W-1:0] store_q;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      for (genvar r = 0; r < BANK_REGS; r++) begin : g_reg
         logic hit0, hit1;
         assign hit0 = we0 && (bank_sel == SEL_W'(b)) && (idx0 == IDX_W'(r));
         assign hit1 = we1 && (bank_sel == SEL_W'(b)) && (idx1 == IDX_W'(r));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               store_q[b][r] <= '0;
            end else if (hit1) begin
               store_q[b][r] <= wd1;
            end else if (hit0) begin
               if (be0[0]) store_q[b][r][HALF_W-1:0]      <= wd0[HALF_W-1:0];
               if (be0[1]) store_q[b][r][DATA_W-1:HALF_W] <= wd0[DATA_W-1:HALF_W];
            end
         end
      end
   end

   assign act_q = store_q[bank_sel];

endmodule

// File: rtl/regset_special.sv
module regset_special
   import regset_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int PC_W   = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PC_W-1:0]   reset_vec,
   input  logic              we_sb,
   input  logic              we_usp,
   input  logic              we_isp,
   input  logic              we_flg,
   input  logic              we_tblo,
   input  logic              we_tbhi,
   input  logic              we_pc,
   input  logic [DATA_W-1:0] wd_word,
   input  logic [DATA_W-1:0] wd_flg,
   input  logic [PC_W-1:0]   wd_pc,
   output logic [DATA_W-1:0] sb_q,
   output logic [DATA_W-1:0] usp_q,
   output logic [DATA_W-1:0] isp_q,
   output logic [DATA_W-1:0] flg_q,
   output logic [PC_W-1:0]   intb_q,
   output logic [PC_W-1:0]   pc_q
);

   localparam int TBHI_W = PC_W - DATA_W;
   localparam logic [DATA_W-1:0] FLG_KEEP =
      DATA_W'(8'hFF) | (DATA_W'((1 << IPL_W) - 1) << IPL_LSB);

   localparam int N_PTR = 3;
   logic [N_PTR-1:0]             ptr_we;
   logic [N_PTR-1:0][DATA_W-1:0] ptr_q;

   assign ptr_we = {we_isp, we_usp, we_sb};

   for (genvar p = 0; p < N_PTR; p++) begin : g_ptr
      always_ff @(posedge clk) begin
         if (!rst_n)         ptr_q[p] <= '0;
         else if (ptr_we[p]) ptr_q[p] <= wd_word;
      end
   end

   assign sb_q  = ptr_q[0];
   assign usp_q = ptr_q[1];
   assign isp_q = ptr_q[2];

   always_ff @(posedge clk) begin
      if (!rst_n)      flg_q <= '0;
      else if (we_flg) flg_q <= wd_flg & FLG_KEEP;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         intb_q <= '0;
      end else begin
         if (we_tblo) intb_q[DATA_W-1:0]    <= wd_word;
         if (we_tbhi) intb_q[PC_W-1:DATA_W] <= wd_word[TBHI_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     pc_q <= reset_vec;
      else if (we_pc) pc_q <= wd_pc;
   end

endmodule

// File: rtl/cpu_regset.sv
module cpu_regset
   import regset_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int PC_W      = 20,
   parameter int NUM_BANKS = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [PC_W-1:0]       reset_vec,
   input  logic                  wr_en,
   input  logic [3:0]            wr_sel,
   input  logic [1:0]            wr_size,
   input  logic [2*DATA_W-1:0]   wr_data,
   input  logic                  flg_upd_en,
   input  logic [DATA_W-1:0]     flg_upd_val,
   input  logic [3:0]            rd_sel,
   input  logic [1:0]            rd_size,
   output logic [2*DATA_W-1:0]   rd_data,
   output logic [DATA_W-1:0]     sp_o,
   output logic [DATA_W-1:0]     flg_o,
   output logic [PC_W-1:0]       pc_o,
   output logic [PC_W-1:0]       intb_o,
   output logic                  err_o
);

   localparam int LONG_W = 2 * DATA_W;
   localparam int HALF_W = DATA_W / 2;
   localparam int TBHI_W = PC_W - DATA_W;
   localparam int BSEL_W = $clog2(NUM_BANKS);

   if (DATA_W < 16 || (DATA_W % 2) != 0) begin : g_bad_data_w
      $error("cpu_regset: DATA_W must be even and at least 16");
   end
   if (PC_W <= DATA_W || PC_W > LONG_W) begin : g_bad_pc_w
      $error("cpu_regset: PC_W must lie above DATA_W and within 2*DATA_W");
   end
   if (NUM_BANKS != 2) begin : g_bad_banks
      $error("cpu_regset: a single select flag supports exactly two banks");
   end

   dec_t wdec, rdec;

   regset_decode u_wdec (.sel(wr_sel), .size(wr_size), .dec(wdec));
   regset_decode u_rdec (.sel(rd_sel), .size(rd_size), .dec(rdec));

   logic [DATA_W-1:0] sb_q, usp_q, isp_q, flg_q;
   logic [PC_W-1:0]   intb_q, pc_q;
   logic [BANK_REGS-1:0][DATA_W-1:0] bank_q;

   logic              wr_ok;
   logic              we0, we1;
   logic [IDX_W-1:0]  idx1;
   logic [DATA_W-1:0] wd0;
   logic [BSEL_W-1:0] bank_sel;

   assign wr_ok    = wr_en && wdec.legal;
   assign we0      = wr_ok && wdec.bank_hit;
   assign we1      = we0 && wdec.pair;
   assign idx1     = wdec.bank_idx + IDX_W'(2);
   assign wd0      = (size_e'(wr_size) == SZ_HI) ? {2{wr_data[HALF_W-1:0]}}
                                                  : wr_data[DATA_W-1:0];
   assign bank_sel = BSEL_W'(flg_q[FLG_B]);

   regset_bank #(.DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .bank_sel (bank_sel),
      .we0      (we0),
      .idx0     (wdec.bank_idx),
      .be0      ({wdec.be_hi, wdec.be_lo}),
      .wd0      (wd0),
      .we1      (we1),
      .idx1     (idx1),
      .wd1      (wr_data[LONG_W-1:DATA_W]),
      .act_q    (bank_q)
   );

   logic we_sb, we_usp, we_isp, we_tblo, we_tbhi, we_pc;
   logic port_flg, we_flg;
   logic [DATA_W-1:0] wd_flg;
   sel_e ws;

   assign ws       = sel_e'(wr_sel);
   assign we_sb    = wr_ok && (ws == SEL_SB);
   assign we_usp   = wr_ok && ((ws == SEL_USP) || ((ws == SEL_SP) &&  flg_q[FLG_U]));
   assign we_isp   = wr_ok && ((ws == SEL_ISP) || ((ws == SEL_SP) && !flg_q[FLG_U]));
   assign we_tblo  = wr_ok && (ws == SEL_TBLO);
   assign we_tbhi  = wr_ok && (ws == SEL_TBHI);
   assign we_pc    = wr_ok && (ws == SEL_PC);
   assign port_flg = wr_ok && (ws == SEL_FLG);
   assign we_flg   = port_flg || flg_upd_en;
   assign wd_flg   = port_flg ? wr_data[DATA_W-1:0] : flg_upd_val;

   regset_special #(.DATA_W(DATA_W), .PC_W(PC_W)) u_special (
      .clk       (clk),
      .rst_n     (rst_n),
      .reset_vec (reset_vec),
      .we_sb     (we_sb),
      .we_usp    (we_usp),
      .we_isp    (we_isp),
      .we_flg    (we_flg),
      .we_tblo   (we_tblo),
      .we_tbhi   (we_tbhi),
      .we_pc     (we_pc),
      .wd_word   (wr_data[DATA_W-1:0]),
      .wd_flg    (wd_flg),
      .wd_pc     (wr_data[PC_W-1:0]),
      .sb_q      (sb_q),
      .usp_q     (usp_q),
      .isp_q     (isp_q),
      .flg_q     (flg_q),
      .intb_q    (intb_q),
      .pc_q      (pc_q)
   );

   logic [DATA_W-1:0] act_sp;
   assign act_sp = flg_q[FLG_U] ? usp_q : isp_q;

   logic [DATA_W-1:0] rword;
   logic [IDX_W-1:0]  rpair_idx;
   assign rword     = bank_q[rdec.bank_idx];
   assign rpair_idx = rdec.bank_idx + IDX_W'(2);

   always_comb begin
      rd_data = '0;
      if (rdec.legal) begin
         if (rdec.bank_hit) begin
            unique case (size_e'(rd_size))
               SZ_LO:   rd_data[HALF_W-1:0] = rword[HALF_W-1:0];
               SZ_HI:   rd_data[HALF_W-1:0] = rword[DATA_W-1:HALF_W];
               SZ_WORD: rd_data[DATA_W-1:0] = rword;
               SZ_PAIR: rd_data             = {bank_q[rpair_idx], rword};
            endcase
         end else begin
            unique case (sel_e'(rd_sel))
               SEL_SB:   rd_data[DATA_W-1:0] = sb_q;
               SEL_USP:  rd_data[DATA_W-1:0] = usp_q;
               SEL_ISP:  rd_data[DATA_W-1:0] = isp_q;
               SEL_SP:   rd_data[DATA_W-1:0] = act_sp;
               SEL_FLG:  rd_data[DATA_W-1:0] = flg_q;
               SEL_TBLO: rd_data[DATA_W-1:0] = intb_q[DATA_W-1:0];
               SEL_TBHI: rd_data[TBHI_W-1:0] = intb_q[PC_W-1:DATA_W];
               SEL_PC:   rd_data[PC_W-1:0]   = pc_q;
               default:  rd_data             = '0;
            endcase
         end
      end
   end

   logic err_q;
   always_ff @(posedge clk) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= wr_en && !wdec.legal;
   end

   assign sp_o   = act_sp;
   assign flg_o  = flg_q;
   assign pc_o   = pc_q;
   assign intb_o = intb_q;
   assign err_o  = err_q;

endmodule

// File: rtl/regset_checker.sv
module regset_checker #(
   parameter int DATA_W = 16,
   parameter int PC_W   = 20
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic [3:0]          wr_sel,
   input logic [1:0]          wr_size,
   input logic                flg_upd_en,
   input logic [3:0]          rd_sel,
   input logic [1:0]          rd_size,
   input logic [2*DATA_W-1:0] rd_data,
   input logic [DATA_W-1:0]   sp_o,
   input logic [DATA_W-1:0]   flg_o,
   input logic [PC_W-1:0]     pc_o,
   input logic [PC_W-1:0]     intb_o,
   input logic                err_o
);

   function automatic logic combo_ok(input logic [3:0] s, input logic [1:0] z);
      if (s < 4'd2)        return 1'b1;
      else if (s < 4'd14)  return z == 2'd2;
      else if (s == 4'd14) return z == 2'd3;
      else                 return 1'b0;
   endfunction

   logic wr_bad, rd_bad, armed;
   assign wr_bad = wr_en && !combo_ok(wr_sel, wr_size);
   assign rd_bad = !combo_ok(rd_sel, rd_size);

   always_ff @(posedge clk) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   assert_reserved_flags_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flg_o & ~16'h70FF) == '0);

   assert_err_follows_bad_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (err_o == $past(wr_bad)));

   assert_bad_read_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_bad |-> (rd_data == '0));

   assert_bad_write_no_effect_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_bad && !flg_upd_en) |=> ($stable(flg_o) && $stable(pc_o) && $stable(sp_o) && $stable(intb_o)));

   assert_pc_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_sel == 4'd14 && wr_size == 2'd3) |=> $stable(pc_o));

   assert_sp_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !flg_upd_en) |=> $stable(sp_o));

endmodule

bind cpu_regset regset_checker #(.DATA_W(DATA_W), .PC_W(PC_W)) i_regset_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_sel     (wr_sel),
   .wr_size    (wr_size),
   .flg_upd_en (flg_upd_en),
   .rd_sel     (rd_sel),
   .rd_size    (rd_size),
   .rd_data    (rd_data),
   .sp_o       (sp_o),
   .flg_o      (flg_o),
   .pc_o       (pc_o),
   .intb_o     (intb_o),
   .err_o      (err_o)
);

// File: tb/test_cpu_regset.sv
module test_cpu_regset;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [19:0] reset_vec;
   logic        wr_en;
   logic [3:0]  wr_sel;
   logic [1:0]  wr_size;
   logic [31:0] wr_data;
   logic        flg_upd_en;
   logic [15:0] flg_upd_val;
   logic [3:0]  rd_sel;
   logic [1:0]  rd_size;
   logic [31:0] rd_data;
   logic [15:0] sp_o, flg_o;
   logic [19:0] pc_o, intb_o;
   logic        err_o;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   cpu_regset i_cpu_regset (
      .clk(clk), .rst_n(rst_n), .reset_vec(reset_vec),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_size(wr_size), .wr_data(wr_data),
      .flg_upd_en(flg_upd_en), .flg_upd_val(flg_upd_val),
      .rd_sel(rd_sel), .rd_size(rd_size), .rd_data(rd_data),
      .sp_o(sp_o), .flg_o(flg_o), .pc_o(pc_o), .intb_o(intb_o), .err_o(err_o)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [3:0] s, input logic [1:0] z, input logic [31:0] d);
      wr_en = 1'b1; wr_sel = s; wr_size = z; wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic chk_rd(input string tag, input logic [3:0] s, input logic [1:0] z,
                         input logic [31:0] exp);
      rd_sel = s; rd_size = z;
      #2;
      chk(tag, rd_data, exp);
   endtask

   task automatic t_reset;
      for (int s = 0; s < 10; s++) chk_rd("R1 reg zero", 4'(s), 2'd2, 32'h0);
      chk("R1 flags", {16'h0, flg_o}, 32'h0);
      chk("R1 pc", {12'h0, pc_o}, 32'h000A5C3E);
      chk_rd("R1 pc read", 4'd14, 2'd3, 32'h000A5C3E);
      chk("R1 sp", {16'h0, sp_o}, 32'h0);
      chk("R1 intb", {12'h0, intb_o}, 32'h0);
      chk("R1 err", {31'h0, err_o}, 32'h0);
   endtask

   task automatic t_words;
      for (int s = 0; s < 10; s++) wr(4'(s), 2'd2, 32'hFFFF0000 | 32'(16'h1100 + s * 16'h0111));
      for (int s = 0; s < 10; s++) chk_rd("R2 word", 4'(s), 2'd2, 32'(16'h1100 + s * 16'h0111));
   endtask

   task automatic t_bytes;
      wr(4'd0, 2'd2, 32'h1234);
      wr(4'd0, 2'd0, 32'hFFFF_FFAB);
      chk_rd("R3 lo write", 4'd0, 2'd2, 32'h12AB);
      wr(4'd0, 2'd1, 32'h0000_00CD);
      chk_rd("R3 hi write", 4'd0, 2'd2, 32'hCDAB);
      chk_rd("R3 lo read", 4'd0, 2'd0, 32'h00AB);
      chk_rd("R3 hi read", 4'd0, 2'd1, 32'h00CD);
      wr(4'd1, 2'd2, 32'h5678);
      wr(4'd1, 2'd1, 32'h0000_0099);
      chk_rd("R3 r1 hi", 4'd1, 2'd2, 32'h9978);
   endtask

   task automatic t_pair;
      wr(4'd0, 2'd3, 32'hDEAD_BEEF);
      chk_rd("R4 r0 half", 4'd0, 2'd2, 32'hBEEF);
      chk_rd("R4 r2 half", 4'd2, 2'd2, 32'hDEAD);
      chk_rd("R4 r2r0", 4'd0, 2'd3, 32'hDEAD_BEEF);
      wr(4'd1, 2'd3, 32'h0102_0304);
      chk_rd("R4 r3", 4'd3, 2'd2, 32'h0102);
      chk_rd("R4 r3r1", 4'd1, 2'd3, 32'h0102_0304);
   endtask

   task automatic t_banks;
      wr(4'd11, 2'd2, 32'h0);
      for (int s = 0; s < 7; s++) wr(4'(s), 2'd2, 32'(16'hA000 + s));
      wr(4'd11, 2'd2, 32'h0010);
      for (int s = 0; s < 7; s++) wr(4'(s), 2'd2, 32'(16'hB000 + s));
      for (int s = 0; s < 7; s++) chk_rd("R5 bank1", 4'(s), 2'd2, 32'(16'hB000 + s));
      wr(4'd11, 2'd2, 32'h0);
      for (int s = 0; s < 7; s++) chk_rd("R5 bank0", 4'(s), 2'd2, 32'(16'hA000 + s));
   endtask

   task automatic t_stack;
      wr(4'd11, 2'd2, 32'h0);
      wr(4'd8, 2'd2, 32'h0);
      wr(4'd10, 2'd2, 32'h1111);
      chk_rd("R6 isp via sp", 4'd9, 2'd2, 32'h1111);
      chk("R6 sp_o isp", {16'h0, sp_o}, 32'h1111);
      wr(4'd11, 2'd2, 32'h0080);
      chk("R6 sp_o usp", {16'h0, sp_o}, 32'h0);
      wr(4'd10, 2'd2, 32'h2222);
      chk_rd("R6 usp", 4'd8, 2'd2, 32'h2222);
      chk_rd("R6 isp kept", 4'd9, 2'd2, 32'h1111);
      chk_rd("R6 sp read", 4'd10, 2'd2, 32'h2222);
      wr(4'd11, 2'd2, 32'h0);
   endtask

   task automatic t_flags;
      wr(4'd11, 2'd2, 32'hFFFF_FFFF);
      chk_rd("R7 mask write", 4'd11, 2'd2, 32'h70FF);
      chk("R7 flg_o", {16'h0, flg_o}, 32'h70FF);
      flg_upd_en = 1'b1; flg_upd_val = 16'h8F5A;
      @(posedge clk); @(negedge clk);
      flg_upd_en = 1'b0;
      chk("R7 update port mask", {16'h0, flg_o}, 32'h005A);
      wr(4'd11, 2'd2, 32'h0);
   endtask

   task automatic t_intb;
      wr(4'd12, 2'd2, 32'h0000_C0DE);
      wr(4'd13, 2'd2, 32'h0000_FFF7);
      chk("R8 intb", {12'h0, intb_o}, 32'h7C0DE);
      chk_rd("R8 hi read", 4'd13, 2'd2, 32'h7);
      chk_rd("R8 lo read", 4'd12, 2'd2, 32'hC0DE);
   endtask

   task automatic t_pc;
      wr(4'd14, 2'd3, 32'hFFF1_2345);
      chk("R9 pc_o", {12'h0, pc_o}, 32'h12345);
      chk_rd("R9 pc read", 4'd14, 2'd3, 32'h12345);
   endtask

   task automatic t_flag_timing;
      wr(4'd11, 2'd2, 32'h0010);
      wr(4'd0, 2'd2, 32'h1111);
      wr(4'd11, 2'd2, 32'h0);
      wr(4'd0, 2'd2, 32'h2222);
      flg_upd_en = 1'b1; flg_upd_val = 16'h0010;
      wr_en = 1'b1; wr_sel = 4'd0; wr_size = 2'd2; wr_data = 32'h5A5A;
      chk_rd("R10 before edge", 4'd0, 2'd2, 32'h2222);
      @(posedge clk); @(negedge clk);
      flg_upd_en = 1'b0; wr_en = 1'b0;
      chk("R10 bank flag set", {16'h0, flg_o}, 32'h0010);
      chk_rd("R10 bank1 untouched", 4'd0, 2'd2, 32'h1111);
      wr(4'd11, 2'd2, 32'h0);
      chk_rd("R10 old bank written", 4'd0, 2'd2, 32'h5A5A);
      flg_upd_en = 1'b1; flg_upd_val = 16'h0004;
      wr(4'd11, 2'd2, 32'h0001);
      flg_upd_en = 1'b0;
      chk("R10 port priority", {16'h0, flg_o}, 32'h0001);
      wr(4'd11, 2'd2, 32'h0);
   endtask

   task automatic t_illegal;
      wr(4'd2, 2'd2, 32'h3333);
      chk("R11 legal no err", {31'h0, err_o}, 32'h0);
      wr(4'd2, 2'd0, 32'h0000_00FF);
      chk("R11 err pulse", {31'h0, err_o}, 32'h1);
      chk_rd("R11 r2 untouched", 4'd2, 2'd2, 32'h3333);
      @(negedge clk);
      chk("R11 err one cycle", {31'h0, err_o}, 32'h0);
      chk_rd("R11 byte read r2", 4'd2, 2'd1, 32'h0);
      chk_rd("R11 none read", 4'd15, 2'd2, 32'h0);
      chk_rd("R11 pc word read", 4'd14, 2'd2, 32'h0);
      wr(4'd14, 2'd2, 32'h0005_4321);
      chk("R11 pc word write", {12'h0, pc_o}, 32'h12345);
      chk("R11 err pc", {31'h0, err_o}, 32'h1);
      wr(4'd11, 2'd3, 32'h0000_0090);
      chk("R11 flag pair write", {16'h0, flg_o}, 32'h0);
   endtask

   initial begin
      rst_n = 1'b0; reset_vec = 20'hA5C3E;
      wr_en = 1'b0; wr_sel = '0; wr_size = '0; wr_data = '0;
      flg_upd_en = 1'b0; flg_upd_val = '0; rd_sel = '0; rd_size = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_words();
      t_bytes();
      t_pair();
      t_banks();
      t_stack();
      t_flags();
      t_intb();
      t_pc();
      t_flag_timing();
      t_illegal();
      done = 1'b1;
   end

   initial begin
      for (int i = 0; i < 20000; i++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: got timeout expected completion");
      end
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

endmodule